// File: doc/BRIEF.md
# Three-Phase Gate Command Conditioner

This block sits between a PWM generator and the six gate drivers of a three-phase bridge. It takes one high-side and one low-side command per phase leg (U, V, W). All six commands are active low and asynchronous. It produces six active-high gate enables that are safe to pass to the power stage.

Each command goes through a two-flop synchronizer and then a pulse-rejection filter. High-side turn-off uses its own shorter acceptance rule. After an accepted high-side turn-off, the channel is held off for a minimum span. A per-leg guard never lets both switches of a leg conduct at once. It forces the leg off when both sides are requested together, and it inserts a fixed deadtime before the opposite switch of a leg may turn on. A synchronous force-off input clears every output at the next clock edge. All times are parameters counted in clock cycles.

The block has no data stream, so it has no valid/ready handshake. Every pin is a plain level.

Top module: `gate_cmd_conditioner`

## Requirements
- R1: After reset, and while every command is high (idle), all six gate outputs are 0.
- R2: A low-side command level (low = on, high = off) is accepted only after it has been stable for FILT_CYC cycles. The gate output changes FILT_CYC+3 cycles after the input change. A pulse of FILT_CYC-1 cycles has no effect.
- R3: A high-side turn-on request is accepted under the same FILT_CYC rule, with the same FILT_CYC+3 latency. Every channel has the same pipeline depth.
- R4: A high-side off request shorter than HOFF_MIN_CYC cycles is ignored. An off request of at least HOFF_MIN_CYC cycles turns the high gate off HOFF_MIN_CYC+3 cycles after the request began.
- R5: After an accepted high-side turn-off, the high gate turns on again no earlier than HOFF_SPAN_CYC+FILT_CYC+3 cycles after the off request began. It also waits at least FILT_CYC+3 cycles after the command returns low.
- R6: When the high and low commands of one leg both request on, both gates of that leg are off.
- R7: The high and low gates of one leg are never 1 in the same cycle.
- R8: When a gate of a leg turns off, the opposite gate of that leg does not turn on until DEAD_CYC cycles later.
- R9: force_off = 1 drives all six gates to 0 at the next clock edge. When force_off returns to 0, no gate turns on until DEAD_CYC cycles after the first edge that samples it low.
- R10: Vector index 0, 1 and 2 of each command and gate port is phase U, V and W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_cmd_n | input | 3 | High-side commands, active low, asynchronous |
| lo_cmd_n | input | 3 | Low-side commands, active low, asynchronous |
| force_off | input | 1 | Synchronous disable of all gates, active high |
| hi_gate | output | 3 | High-side gate enables |
| lo_gate | output | 3 | Low-side gate enables |

## Verification
Each result has a fixed due cycle, counted from the falling edge at which the bench drives the stimulus:
- A filtered turn-on, or a low-side turn-off, is due FILT_CYC+3 clock edges later: two synchronizer stages, the filter and the guard register.
- A high-side turn-off is due HOFF_MIN_CYC+3 edges later.
- A high-side re-turn-on after a mid-length off pulse is due HOFF_SPAN_CYC+FILT_CYC+3 edges after the off request began.
- The opposite gate of a hand-over is due DEAD_CYC edges after the gate that turns off.
- A force-off result is due one edge later.

The driver pushes each expected gate change into the queue with this exact cycle. The monitor samples the gates on falling edges and compares every observed change with the head of the queue: channel, level and cycle. Any change that was not expected is a failure. This covers rejected pulses and interlocked legs, where no change may happen.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
  // which side of a leg conducted last before the current gap
  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_HI   = 2'd1,
    SIDE_LO   = 2'd2
  } side_e;
endpackage

// File: rtl/gcc_sync.sv
module gcc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  // resets to 1: an idle (high) active-low command means off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/gcc_filter.sv
module gcc_filter #(
  parameter int FILT      = 27,
  parameter int OFF_MIN   = 22,
  parameter int OFF_SPAN  = 40,
  parameter bit HIGH_SIDE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic acc
);
  localparam int OFF_N  = HIGH_SIDE ? OFF_MIN : FILT;
  localparam int HOLD_N = HIGH_SIDE ? (OFF_SPAN - OFF_MIN) : 0;
  localparam int CMAX   = (FILT > OFF_N) ? FILT : OFF_N;
  localparam int CW     = $clog2(CMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          acc_q;
  logic          busy;

  // acceptance length depends on the direction of the pending change
  assign lim = acc_q ? CW'(OFF_N - 1) : CW'(FILT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      cnt   <= '0;
    end else if (busy) begin
      cnt <= '0;
    end else if (req == acc_q) begin
      cnt <= '0;
    end else if (cnt == lim) begin
      acc_q <= req;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign acc = acc_q;

  generate
    if (HOLD_N > 0) begin : g_hold
      localparam int HW = $clog2(HOLD_N + 1);
      logic [HW-1:0] hold;
      logic          take_off;

      assign take_off = acc_q & ~req & (cnt == lim) & ~busy;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           hold <= '0;
        else if (take_off)    hold <= HW'(HOLD_N);
        else if (hold != '0)  hold <= hold - 1'b1;
      end

      assign busy = (hold != '0);

      // R5
      hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !acc_q);
    end else begin : g_nohold
      assign busy = 1'b0;
    end
  endgenerate

  // R2
  filt_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q != $past(acc_q)) |-> ($past(req) == acc_q));
endmodule

// File: rtl/gcc_leg_guard.sv
module gcc_leg_guard
  import gcc_pkg::*;
#(
  parameter int DEAD = 38
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dis,
  input  logic hi_req,
  input  logic lo_req,
  output logic hi_on,
  output logic lo_on
);
  localparam int DW = $clog2(DEAD + 1);

  logic [DW-1:0] gap;
  side_e         last;
  logic          h_q, l_q, h_nx, l_nx;
  logic          want_h, want_l, gap_done;

  // a leg asked to conduct on both sides gets neither
  assign want_h   = hi_req & ~lo_req;
  assign want_l   = lo_req & ~hi_req;
  assign gap_done = (gap == '0);

  assign h_nx = ~dis & want_h & ~l_q & (h_q | gap_done | (last == SIDE_HI));
  assign l_nx = ~dis & want_l & ~h_q & (l_q | gap_done | (last == SIDE_LO));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q  <= 1'b0;
      l_q  <= 1'b0;
      gap  <= '0;
      last <= SIDE_NONE;
    end else begin
      h_q <= h_nx;
      l_q <= l_nx;
      if (dis) begin
        gap  <= DW'(DEAD);
        last <= SIDE_NONE;
      end else if (h_q & ~h_nx) begin
        gap  <= DW'(DEAD - 1);
        last <= SIDE_HI;
      end else if (l_q & ~l_nx) begin
        gap  <= DW'(DEAD - 1);
        last <= SIDE_LO;
      end else if (!gap_done) begin
        gap <= gap - 1'b1;
      end
    end
  end

  assign hi_on = h_q;
  assign lo_on = l_q;

  // R7
  leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_q && l_q));

  // R9
  force_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> (!h_q && !l_q));

  // R8
  lo_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l_q) |-> !$past(h_q));

  // R8
  hi_after_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h_q) |-> !$past(l_q));
endmodule

// File: rtl/gate_cmd_conditioner.sv
module gate_cmd_conditioner #(
  parameter int NLEG          = 3,
  parameter int SYNC_STAGES   = 2,
  parameter int FILT_CYC      = 27,
  parameter int HOFF_MIN_CYC  = 22,
  parameter int HOFF_SPAN_CYC = 40,
  parameter int DEAD_CYC      = 38
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLEG-1:0] hi_cmd_n,
  input  logic [NLEG-1:0] lo_cmd_n,
  input  logic            force_off,
  output logic [NLEG-1:0] hi_gate,
  output logic [NLEG-1:0] lo_gate
);
  logic [NLEG-1:0] hi_s_n, lo_s_n, hi_acc, lo_acc;

  // R10: index 0/1/2 = phase U/V/W on every vector
  genvar i;
  generate
    for (i = 0; i < NLEG; i++) begin : g_leg
      gcc_sync #(.STAGES(SYNC_STAGES)) u_hsync (
        .clk(clk), .rst_n(rst_n), .d(hi_cmd_n[i]), .q(hi_s_n[i]));
      gcc_sync #(.STAGES(SYNC_STAGES)) u_lsync (
        .clk(clk), .rst_n(rst_n), .d(lo_cmd_n[i]), .q(lo_s_n[i]));

      gcc_filter #(.FILT(FILT_CYC), .OFF_MIN(HOFF_MIN_CYC),
                   .OFF_SPAN(HOFF_SPAN_CYC), .HIGH_SIDE(1'b1)) u_hfilt (
        .clk(clk), .rst_n(rst_n), .req(~hi_s_n[i]), .acc(hi_acc[i]));
      gcc_filter #(.FILT(FILT_CYC), .OFF_MIN(HOFF_MIN_CYC),
                   .OFF_SPAN(HOFF_SPAN_CYC), .HIGH_SIDE(1'b0)) u_lfilt (
        .clk(clk), .rst_n(rst_n), .req(~lo_s_n[i]), .acc(lo_acc[i]));

      gcc_leg_guard #(.DEAD(DEAD_CYC)) u_guard (
        .clk(clk), .rst_n(rst_n), .dis(force_off),
        .hi_req(hi_acc[i]), .lo_req(lo_acc[i]),
        .hi_on(hi_gate[i]), .lo_on(lo_gate[i]));
    end
  endgenerate
endmodule

// File: tb/tb_gate_cmd_conditioner.sv
module tb_gate_cmd_conditioner;
  localparam int FILT = 27, HMIN = 22, HSPAN = 40, DEAD = 38;
  localparam int LAT_ON  = FILT + 3;
  localparam int LAT_HOF = HMIN + 3;

  logic clk = 1'b0, rst_n = 1'b0, force_off = 1'b0;
  logic [2:0] hi_cmd_n = 3'b111, lo_cmd_n = 3'b111;
  logic [2:0] hi_gate, lo_gate;

  gate_cmd_conditioner dut (
    .clk(clk), .rst_n(rst_n), .hi_cmd_n(hi_cmd_n), .lo_cmd_n(lo_cmd_n),
    .force_off(force_off), .hi_gate(hi_gate), .lo_gate(lo_gate));

  always #5 clk = ~clk;

  typedef struct { int ch; bit val; int cyc; string req; } exp_t;
  exp_t q[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  logic [5:0] gv, gprev;
  assign gv = {lo_gate, hi_gate};  // ch 0..2 high U/V/W, 3..5 low U/V/W

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_ev(int ch, bit val, int dly, string req);
    exp_t e;
    e.ch = ch; e.val = val; e.cyc = cyc + dly; e.req = req;
    q.push_back(e);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: every gate change must match the head of the queue
  always @(negedge clk) begin
    if (!rst_n) gprev = gv;
    else begin
      for (int c = 0; c < 6; c++) begin
        if (gv[c] != gprev[c]) begin
          n_chk++;
          if (q.size() == 0) begin
            n_fail++;
            $display("FAIL unexpected change ch=%0d actual=%0b cyc=%0d expected none",
                     c, gv[c], cyc);
          end else begin
            exp_t e;
            e = q.pop_front();
            if (e.ch != c || e.val != gv[c] || e.cyc != cyc) begin
              n_fail++;
              $display("FAIL %s actual ch=%0d val=%0b cyc=%0d expected ch=%0d val=%0b cyc=%0d",
                       e.req, c, gv[c], cyc, e.ch, e.val, e.cyc);
            end
          end
        end
      end
      gprev = gv;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    check(gv == 6'b0, "R1 reset state", gv, 0);
    rst_n = 1'b1;
    idle(60);
    check(gv == 6'b0, "R1 idle after reset", gv, 0);

    // R2: low-side U on then off
    lo_cmd_n[0] = 1'b0; expect_ev(3, 1, LAT_ON, "R2 lo on");
    idle(40);
    lo_cmd_n[0] = 1'b1; expect_ev(3, 0, LAT_ON, "R2 lo off");
    idle(100);

    // R2: FILT-1 pulse rejected, FILT pulse accepted
    lo_cmd_n[0] = 1'b0; idle(FILT - 1); lo_cmd_n[0] = 1'b1;
    idle(60);
    check(gv == 6'b0 && q.size() == 0, "R2 short pulse ignored", gv, 0);
    lo_cmd_n[0] = 1'b0; expect_ev(3, 1, LAT_ON, "R2 exact pulse on");
    idle(FILT);
    lo_cmd_n[0] = 1'b1; expect_ev(3, 0, LAT_ON, "R2 exact pulse off");
    idle(100);

    // R3/R8: leg V high on, hand over to low, back to high
    hi_cmd_n[1] = 1'b0; expect_ev(1, 1, LAT_ON, "R3 hi on");
    idle(60);
    hi_cmd_n[1] = 1'b1; lo_cmd_n[1] = 1'b0;
    expect_ev(1, 0, LAT_HOF, "R4 hi off");
    expect_ev(4, 1, LAT_HOF + DEAD, "R8 lo after deadtime");
    idle(120);
    lo_cmd_n[1] = 1'b1; hi_cmd_n[1] = 1'b0;
    expect_ev(4, 0, LAT_ON, "R2 lo off in handover");
    expect_ev(1, 1, LAT_ON + DEAD, "R8 hi after deadtime");
    idle(120);
    hi_cmd_n[1] = 1'b1; expect_ev(1, 0, LAT_HOF, "R4 hi off V");
    idle(100);

    // R6: leg W both requested stays off
    hi_cmd_n[2] = 1'b0; lo_cmd_n[2] = 1'b0;
    idle(70);
    check(gv[2] == 1'b0 && gv[5] == 1'b0 && q.size() == 0, "R6 both requested off",
          {gv[5], gv[2]}, 0);
    lo_cmd_n[2] = 1'b1; expect_ev(2, 1, LAT_ON, "R6 hi after lo released");
    idle(80);

    // R4: high-side off shorter than HMIN ignored
    hi_cmd_n[2] = 1'b1; idle(HMIN - 1); hi_cmd_n[2] = 1'b0;
    idle(60);
    check(gv[2] == 1'b1 && q.size() == 0, "R4 short off ignored", gv[2], 1);

    // R5: mid-length off pulse is stretched
    hi_cmd_n[2] = 1'b1;
    expect_ev(2, 0, LAT_HOF, "R4 mid off accepted");
    expect_ev(2, 1, HSPAN + FILT + 3, "R5 hi re-on after span");
    idle(30); hi_cmd_n[2] = 1'b0;
    idle(90);

    // R9: force off and restart of deadtime
    lo_cmd_n[0] = 1'b0; expect_ev(3, 1, LAT_ON, "R2 lo U on");
    idle(60);
    force_off = 1'b1;
    expect_ev(2, 0, 1, "R9 force hi W off");
    expect_ev(3, 0, 1, "R9 force lo U off");
    idle(5);
    force_off = 1'b0;
    expect_ev(2, 1, 1 + DEAD, "R9 hi W after release");
    expect_ev(3, 1, 1 + DEAD, "R9 lo U after release");
    idle(80);

    // R3/R10: release both, each channel at its own latency
    hi_cmd_n[2] = 1'b1; lo_cmd_n[0] = 1'b1;
    expect_ev(2, 0, LAT_HOF, "R10 hi W off");
    expect_ev(3, 0, LAT_ON, "R10 lo U off");
    idle(80);
    check(q.size() == 0, "R3 all expected changes seen", q.size(), 0);
    check(gv == 6'b0, "R1 final idle", gv, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule